// File: doc/BRIEF.md
# Peripheral Reset Register Bank

This block is a small bank of 32-bit registers that software writes in order to hold or release on-chip peripherals and two processor cores in reset. Each register keeps only the bits it defines; all other bits read back as zero. Each peripheral reset output is a synchronous level that follows its stored bit. Coming out of reset, every peripheral is held in reset.

The two core bits work differently from the peripheral bits. On each write to the core register, the block compares the old value of each core bit with the new one. A 0-to-1 change powers the core off. That power-off is a level that holds until the bit is cleared again. A 1-to-0 change lifts the power-off and produces a one-cycle start pulse, which starts the core from its reset vector. Writing back the value a bit already holds causes no action. One register bit drives the resets of every DMA channel together.

The register index is the word address on a simple write-strobe bus. The read data is combinational from the address.

Top module: `crst_bank`

## Requirements
- R1: After synchronous reset the registers read: index 0 (core) 0x17, index 1 (DMA group) 0x1, indices 2..13 (peripherals, output bit k from index 2+k) 0x1, index 14 (debug) 0x33, index 15 (timer) 0xF, index 16 (power domain) 0x3, index 17 (reset mode) 0x1. Core power-off outputs are both high and the start pulses are low.
- R2: Only these bits are kept on a write: 0xF7 at index 0, 0x1 at indices 1..13, 0x33 at index 14, 0xF at index 15, 0x3 at index 16 and 0x7 at index 17. Every other bit reads zero and ignores writes.
- R3: A write that changes core bit c (c = 0 or 1 of index 0) from 0 to 1 sets `core_off[c]` from the next cycle. The output stays high until the bit is written to 0.
- R4: A write that changes core bit c from 1 to 0 clears `core_off[c]` and raises `core_start[c]` in the cycle after the write.
- R5: Writing a core bit with the value it already holds leaves `core_off` unchanged and produces no start pulse.
- R6: Bit 0 of index 1 drives every bit of `dma_rst` to the same value.
- R7: `periph_rst[k]` equals bit 0 of index 2+k from the cycle after the write.
- R8: `dbg_rst`, `timer_rst`, `pd_rst` and `rst_mode` equal the kept bits of indices 14, 15, 16 and 17, from the cycle after the write.
- R9: Addresses 18 and above read zero, and writes to them change no register and no output.
- R10: Each start pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| core_off | output | 2 | Core power-off levels |
| core_start | output | 2 | Core start-from-reset pulses |
| dma_rst | output | N_DMA | DMA channel resets |
| periph_rst | output | 12 | Single-peripheral resets |
| dbg_rst | output | 8 | Debug reset field |
| timer_rst | output | 4 | Timer reset field |
| pd_rst | output | 2 | Power domain reset field |
| rst_mode | output | 3 | Reset mode field |

## Verification
Directed writes move the core bits through every transition from the reset value: both bits falling at once, a single bit rising, and one bit rising while the other falls. This separates the power-off action from the start pulse and shows that the two cores are independent. Rewriting a held value confirms that a write without a change triggers nothing. All-ones writes expose which bits are reserved. Writes to unmapped addresses show that nothing else moves. Random writes over the whole address range, with periodic full read-backs, compare every output field and every register against a bench model.

// File: rtl/crst_pkg.sv
package crst_pkg;

    localparam int DATA_W   = 32;
    localparam int NREG     = 18;
    localparam int N_CORE   = 2;
    localparam int N_PERIPH = 12;

    localparam int IDX_CORE    = 0;
    localparam int IDX_DMA     = 1;
    localparam int IDX_PERIPH0 = 2;
    localparam int IDX_DBG     = 14;
    localparam int IDX_TMR     = 15;
    localparam int IDX_PD      = 16;
    localparam int IDX_MODE    = 17;

    // Value loaded by synchronous reset
    function automatic logic [DATA_W-1:0] reg_init(input int idx);
        logic [DATA_W-1:0] v;
        if (idx == IDX_CORE)      v = 32'h17;
        else if (idx == IDX_DBG)  v = 32'h33;
        else if (idx == IDX_TMR)  v = 32'hF;
        else if (idx == IDX_PD)   v = 32'h3;
        else if (idx < NREG)      v = 32'h1;
        else                      v = '0;
        return v;
    endfunction

    // Bits that a write keeps; the rest are reserved and read zero
    function automatic logic [DATA_W-1:0] reg_keep(input int idx);
        logic [DATA_W-1:0] v;
        if (idx == IDX_CORE)      v = 32'hF7;
        else if (idx == IDX_DBG)  v = 32'h33;
        else if (idx == IDX_TMR)  v = 32'hF;
        else if (idx == IDX_PD)   v = 32'h3;
        else if (idx == IDX_MODE) v = 32'h7;
        else if (idx < NREG)      v = 32'h1;
        else                      v = '0;
        return v;
    endfunction

    // A write event on the core register: stored bits and incoming bits
    typedef struct packed {
        logic              strobe;
        logic [N_CORE-1:0] prev;
        logic [N_CORE-1:0] next;
    } core_evt_t;

    // Stored reset fields that drive the level outputs
    typedef struct packed {
        logic                dma;
        logic [N_PERIPH-1:0] periph;
        logic [7:0]          dbg;
        logic [3:0]          tmr;
        logic [1:0]          pd;
        logic [2:0]          mode;
    } crst_lines_t;

endpackage

// File: rtl/crst_regfile.sv
module crst_regfile
    import crst_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output core_evt_t         core_evt,
    output crst_lines_t       lines
);

    logic [DATA_W-1:0] q [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            localparam logic [DATA_W-1:0] INIT = reg_init(g);
            localparam logic [DATA_W-1:0] KEEP = reg_keep(g);
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[g] <= INIT;
                end else if (wr && (addr == ADDR_W'(g))) begin
                    q[g] <= wdata & KEEP;
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == ADDR_W'(i)) rdata = q[i];
        end
    end

    always_comb begin
        core_evt.strobe = wr && (addr == ADDR_W'(IDX_CORE));
        core_evt.prev   = q[IDX_CORE][N_CORE-1:0];
        core_evt.next   = wdata[N_CORE-1:0];
    end

    always_comb begin
        lines.dma  = q[IDX_DMA][0];
        lines.dbg  = q[IDX_DBG][7:0];
        lines.tmr  = q[IDX_TMR][3:0];
        lines.pd   = q[IDX_PD][1:0];
        lines.mode = q[IDX_MODE][2:0];
        for (int k = 0; k < N_PERIPH; k++) begin
            lines.periph[k] = q[IDX_PERIPH0 + k][0];
        end
    end

    // R2: a stored reserved bit of the core register never appears
    p_core_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $past(wr) |-> (q[IDX_CORE][3] == 1'b0));

endmodule

// File: rtl/crst_core_ctl.sv
module crst_core_ctl
    import crst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  core_evt_t         evt,
    output logic [N_CORE-1:0] off,
    output logic [N_CORE-1:0] start
);

    localparam logic [DATA_W-1:0] CORE_INIT = reg_init(IDX_CORE);

    generate
        for (genvar c = 0; c < N_CORE; c++) begin : g_core
            logic rise, fall;
            assign rise = evt.strobe && !evt.prev[c] &&  evt.next[c];
            assign fall = evt.strobe &&  evt.prev[c] && !evt.next[c];

            always_ff @(posedge clk) begin
                if (rst) begin
                    off[c]   <= CORE_INIT[c];
                    start[c] <= 1'b0;
                end else begin
                    start[c] <= fall;
                    if (rise)      off[c] <= 1'b1;
                    else if (fall) off[c] <= 1'b0;
                end
            end

            p_off_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
                (evt.strobe && !evt.prev[c] && evt.next[c]) |=> off[c]);

            p_start_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
                (evt.strobe && evt.prev[c] && !evt.next[c]) |=> (start[c] && !off[c]));

            p_no_action_same_r5: assert property (@(posedge clk) disable iff (rst)
                (evt.strobe && (evt.prev[c] == evt.next[c])) |=> (!start[c] && $stable(off[c])));

            p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
                start[c] |=> !start[c]);
        end
    endgenerate

endmodule

// File: rtl/crst_fanout.sv
module crst_fanout
    import crst_pkg::*;
#(
    parameter int N_DMA = 8
) (
    input  crst_lines_t         lines,
    output logic [N_DMA-1:0]    dma_rst,
    output logic [N_PERIPH-1:0] periph_rst,
    output logic [7:0]          dbg_rst,
    output logic [3:0]          timer_rst,
    output logic [1:0]          pd_rst,
    output logic [2:0]          rst_mode
);

    generate
        for (genvar d = 0; d < N_DMA; d++) begin : g_dma
            assign dma_rst[d] = lines.dma;
        end
        for (genvar p = 0; p < N_PERIPH; p++) begin : g_per
            assign periph_rst[p] = lines.periph[p];
        end
    endgenerate

    assign dbg_rst   = lines.dbg;
    assign timer_rst = lines.tmr;
    assign pd_rst    = lines.pd;
    assign rst_mode  = lines.mode;

endmodule

// File: rtl/crst_bank.sv
module crst_bank
    import crst_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int N_DMA  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [N_CORE-1:0]   core_off,
    output logic [N_CORE-1:0]   core_start,
    output logic [N_DMA-1:0]    dma_rst,
    output logic [N_PERIPH-1:0] periph_rst,
    output logic [7:0]          dbg_rst,
    output logic [3:0]          timer_rst,
    output logic [1:0]          pd_rst,
    output logic [2:0]          rst_mode
);

    core_evt_t   core_evt;
    crst_lines_t lines;

    crst_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .core_evt (core_evt),
        .lines    (lines)
    );

    crst_core_ctl u_core (
        .clk   (clk),
        .rst   (rst),
        .evt   (core_evt),
        .off   (core_off),
        .start (core_start)
    );

    crst_fanout #(.N_DMA(N_DMA)) u_fan (
        .lines      (lines),
        .dma_rst    (dma_rst),
        .periph_rst (periph_rst),
        .dbg_rst    (dbg_rst),
        .timer_rst  (timer_rst),
        .pd_rst     (pd_rst),
        .rst_mode   (rst_mode)
    );

    // R3: the power-off level tracks the stored core bits (separate flops)
    p_off_tracks_reg_r3: assert property (@(posedge clk) disable iff (rst)
        core_off == core_evt.prev);

endmodule

// File: tb/test_crst_bank.sv
module test_crst_bank;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int N_DMA  = 8;
    localparam int NREG   = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [1:0]        core_off, core_start;
    logic [N_DMA-1:0]  dma_rst;
    logic [11:0]       periph_rst;
    logic [7:0]        dbg_rst;
    logic [3:0]        timer_rst;
    logic [1:0]        pd_rst;
    logic [2:0]        rst_mode;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    crst_bank #(.ADDR_W(ADDR_W), .N_DMA(N_DMA)) i_crst_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_off(core_off), .core_start(core_start), .dma_rst(dma_rst),
        .periph_rst(periph_rst), .dbg_rst(dbg_rst), .timer_rst(timer_rst),
        .pd_rst(pd_rst), .rst_mode(rst_mode)
    );

    function automatic logic [31:0] init_of(input int i);
        case (i)
            0: return 32'h17;
            14: return 32'h33;
            15: return 32'hF;
            16: return 32'h3;
            default: return (i < NREG) ? 32'h1 : 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] keep_of(input int i);
        case (i)
            0: return 32'hF7;
            14: return 32'h33;
            15: return 32'hF;
            16: return 32'h3;
            17: return 32'h7;
            default: return (i < NREG) ? 32'h1 : 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check_outs(input logic [1:0] exp_start);
        logic [11:0] ep;
        for (int k = 0; k < 12; k++) ep[k] = m[2 + k][0];
        chk(core_off == m[0][1:0], "R3 core_off", 32'(core_off), 32'(m[0][1:0]));
        chk(core_start == exp_start, "R4 core_start", 32'(core_start), 32'(exp_start));
        chk(dma_rst == {N_DMA{m[1][0]}}, "R6 dma_rst", 32'(dma_rst), 32'({N_DMA{m[1][0]}}));
        chk(periph_rst == ep, "R7 periph_rst", 32'(periph_rst), 32'(ep));
        chk({dbg_rst, timer_rst, pd_rst, rst_mode} == {m[14][7:0], m[15][3:0], m[16][1:0], m[17][2:0]},
            "R8 field outputs", 32'({dbg_rst, timer_rst, pd_rst, rst_mode}),
            32'({m[14][7:0], m[15][3:0], m[16][1:0], m[17][2:0]}));
    endtask

    task automatic read_chk(input int a, input string req);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1;
        e = (a < NREG) ? m[a] : 32'h0;
        chk(bus_rdata == e, req, bus_rdata, e);
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 32; a++) read_chk(a, req);
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        logic [1:0] es;
        es = 2'b00;
        if (a < NREG) begin
            if (a == 0) es = m[0][1:0] & ~d[1:0];
            m[a] = d & keep_of(a);
        end
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        check_outs(es);
        @(negedge clk);
        // R10: pulse gone one cycle later
        chk(core_start == 2'b00, "R10 single pulse", 32'(core_start), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < NREG; i++) m[i] = init_of(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check_outs(2'b00);
        chk(core_off == 2'b11, "R1 core_off reset", 32'(core_off), 32'h3);
        read_all("R1 reset readback");

        // R2: reserved bits
        do_write(0, 32'hFFFF_FFFF);
        read_chk(0, "R2 core reserved");
        do_write(14, 32'hFFFF_FFFF);
        read_chk(14, "R2 debug reserved");
        do_write(17, 32'hFFFF_FFFF);
        read_chk(17, "R2 mode reserved");

        // R4: both cores fall together -> start 11, off 00
        do_write(0, 32'h0);
        // R3: core 0 rises
        do_write(0, 32'h1);
        // R5: rewrite same value
        do_write(0, 32'h1);
        do_write(0, 32'h1);
        // R3 and R4 mixed: core 0 falls, core 1 rises
        do_write(0, 32'h2);
        do_write(0, 32'h3);
        do_write(0, 32'h1);

        // R6 and R7: DMA group and a peripheral
        do_write(1, 32'h0);
        do_write(1, 32'h1);
        do_write(5, 32'h0);
        do_write(13, 32'h0);

        // R9: unmapped addresses
        do_write(20, 32'hFFFF_FFFF);
        do_write(31, 32'hFFFF_FFFF);
        read_chk(20, "R9 unmapped read");
        read_all("R9 readback after unmapped writes");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int a;
            a = (($urandom % 4) == 0) ? 0 : int'($urandom % 32);
            do_write(a, $urandom);
            if ((n % 100) == 99) read_all("R2 random readback");
        end

        finish_run();
    end

endmodule